// File: doc/BRIEF.md
# Load-Use Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline and handles the one data dependence that forwarding cannot cover. If a load is in execute and the instruction in decode reads that load's destination register, the unit freezes the fetch address and the fetch/decode register for one cycle. In that same cycle it writes a no-op bubble into the decode/execute register. One cycle later the load has moved on to memory, and a forwarding path outside this block can supply the loaded value.

For test purposes the block contains a small model of the front of the pipeline. This model has a program counter, a fetch/decode register holding the raw instruction word, a minimal control decoder, and a decode/execute register holding control bits and register numbers. An external instruction memory supplies `imem_instr` for the current `pc_out`. Operand forwarding and branch flushing are handled elsewhere.

Top module: `ldu_hazard_top`

## Requirements
- R1: While `rst_n` is low, `pc_out` is 0, `ifid_instr` is 0, and all decode/execute control outputs (`idex_mem_read`, `idex_mem_write`, `idex_reg_write`) are 0. Outside a stall, `pc_we` and `ifid_we` are 1 and `ctrl_zero` is 0.
- R2: Instruction fields are: opcode [31:26], rs [25:21], rt [20:16] and rd [15:11]. Opcode 0x23 is a load: it reads memory, writes a register and its destination is rt. Opcode 0x2B is a store: it writes memory and its data register is rt. Opcode 0x00 is a register operation: it writes a register and its destination is rd. A stall (`ctrl_zero`=1, `pc_we`=0, `ifid_we`=0) is raised when the decode/execute register holds a memory-read instruction whose rt is nonzero and equals the rs or the rt of the instruction in the fetch/decode register.
- R3: An instruction that does not read memory never raises a stall, even when its rt field matches a source register of the next instruction.
- R4: In a stall cycle the next clock edge leaves both `pc_out` and `ifid_instr` unchanged, so the dependent instruction repeats its decode stage.
- R5: Each load-use dependence costs exactly one stall cycle. In the cycle after a stall, `ctrl_zero` is 0.
- R6: The bubble written during a stall has all decode/execute control bits cleared: memory read, memory write and register write are all 0.
- R7: A load whose rt is register 0 never raises a stall.
- R8: When there is no stall, `pc_out` advances by 4 on each clock edge. A load followed by an independent instruction causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| imem_instr | input | 32 | Instruction word at `pc_out` |
| pc_out | output | 16 | Fetch address |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ctrl_zero | output | 1 | Replace the control bits entering decode/execute with a bubble |
| ifid_instr | output | 32 | Instruction held in the fetch/decode register |
| idex_mem_read | output | 1 | Decode/execute memory-read control bit |
| idex_mem_write | output | 1 | Decode/execute memory-write control bit |
| idex_reg_write | output | 1 | Decode/execute register-write control bit |
| idex_rt | output | 5 | rt field held in decode/execute |
| idex_dest | output | 5 | Destination register held in decode/execute |

## Verification
The bench runs short programs and counts stall cycles. It covers a dependence through rs and through rt (a store's data register), which catches a comparator that only looks at one field. It runs a store followed by a read of its rt, which exposes a unit that ignores the memory-read flag. It runs a load into register 0, which shows whether the zero check is missing.

A chain of two dependent loads must cost exactly two stalls. A unit that fails to write the bubble would stall forever. A unit that fails to freeze the fetch/decode register would lose the dependent instruction, and the bench would see the wrong `ifid_instr` and a wrong final `pc_out`.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  localparam int OP_W = 6;
  localparam logic [OP_W-1:0] OP_REG   = 6'h00;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2b;

  typedef struct packed {
    logic mem_read;
    logic mem_write;
    logic reg_write;
  } ctl_t;

  localparam ctl_t CTL_NONE = '{mem_read: 1'b0, mem_write: 1'b0, reg_write: 1'b0};
endpackage

// File: rtl/ldu_decode.sv
module ldu_decode
  import ldu_pkg::*;
#(
  parameter int RA_W = 5
) (
  input  logic [OP_W-1:0] opcode,
  input  logic [RA_W-1:0] fld_rt,
  input  logic [RA_W-1:0] fld_rd,
  output ctl_t            ctl_o,
  output logic [RA_W-1:0] dest_o
);
  always_comb begin
    ctl_o  = CTL_NONE;
    dest_o = '0;
    unique case (opcode)
      OP_LOAD: begin
        ctl_o.mem_read  = 1'b1;
        ctl_o.reg_write = 1'b1;
        dest_o          = fld_rt;
      end
      OP_STORE: begin
        ctl_o.mem_write = 1'b1;
      end
      OP_REG: begin
        ctl_o.reg_write = 1'b1;
        dest_o          = fld_rd;
      end
      default: begin
        ctl_o  = CTL_NONE;
        dest_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/ldu_detect.sv
module ldu_detect #(
  parameter int RA_W = 5,
  parameter int NSRC = 2
) (
  input  logic                      ex_mem_read,
  input  logic [RA_W-1:0]           ex_rt,
  input  logic [NSRC-1:0][RA_W-1:0] src_regs,
  output logic                      stall_o
);
  logic [NSRC-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_cmp
      assign hit[g] = (src_regs[g] == ex_rt);
    end
  endgenerate

  assign stall_o = ex_mem_read && (ex_rt != '0) && (|hit);
endmodule

// File: rtl/ldu_pipe_regs.sv
module ldu_pipe_regs
  import ldu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int PC_W = 16,
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_en,
  input  logic            ifid_en,
  input  logic            bubble,
  input  logic [XLEN-1:0] fetch_word,
  input  ctl_t            dec_ctl,
  input  logic [RA_W-1:0] dec_rt,
  input  logic [RA_W-1:0] dec_dest,
  output logic [PC_W-1:0] pc_q,
  output logic [XLEN-1:0] ifid_q,
  output ctl_t            idex_ctl_q,
  output logic [RA_W-1:0] idex_rt_q,
  output logic [RA_W-1:0] idex_dest_q
);
  localparam int INSN_BYTES = XLEN / 8;

  logic [PC_W-1:0] pc_d;
  logic [XLEN-1:0] ifid_d;
  ctl_t            idex_ctl_d;

  always_comb begin
    pc_d       = pc_en ? pc_q + PC_W'(INSN_BYTES) : pc_q;
    ifid_d     = ifid_en ? fetch_word : ifid_q;
    idex_ctl_d = bubble ? CTL_NONE : dec_ctl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q        <= '0;
      ifid_q      <= '0;
      idex_ctl_q  <= CTL_NONE;
      idex_rt_q   <= '0;
      idex_dest_q <= '0;
    end else begin
      pc_q        <= pc_d;
      ifid_q      <= ifid_d;
      idex_ctl_q  <= idex_ctl_d;
      idex_rt_q   <= dec_rt;
      idex_dest_q <= dec_dest;
    end
  end
endmodule

// File: rtl/ldu_hazard_top.sv
module ldu_hazard_top
  import ldu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int PC_W = 16,
  parameter int RA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] imem_instr,
  output logic [PC_W-1:0] pc_out,
  output logic            pc_we,
  output logic            ifid_we,
  output logic            ctrl_zero,
  output logic [XLEN-1:0] ifid_instr,
  output logic            idex_mem_read,
  output logic            idex_mem_write,
  output logic            idex_reg_write,
  output logic [RA_W-1:0] idex_rt,
  output logic [RA_W-1:0] idex_dest
);
  localparam int OP_LSB = XLEN - OP_W;
  localparam int RS_LSB = OP_LSB - RA_W;
  localparam int RT_LSB = RS_LSB - RA_W;
  localparam int RD_LSB = RT_LSB - RA_W;
  localparam int NSRC   = 2;

  logic [OP_W-1:0]           id_op;
  logic [RA_W-1:0]           id_rs, id_rt, id_rd, dec_dest;
  logic [NSRC-1:0][RA_W-1:0] id_srcs;
  ctl_t                      dec_ctl, idex_ctl;
  logic                      hazard;

  assign id_op   = ifid_instr[OP_LSB +: OP_W];
  assign id_rs   = ifid_instr[RS_LSB +: RA_W];
  assign id_rt   = ifid_instr[RT_LSB +: RA_W];
  assign id_rd   = ifid_instr[RD_LSB +: RA_W];
  assign id_srcs = {id_rt, id_rs};

  ldu_decode #(.RA_W(RA_W)) u_dec (
    .opcode (id_op),
    .fld_rt (id_rt),
    .fld_rd (id_rd),
    .ctl_o  (dec_ctl),
    .dest_o (dec_dest)
  );

  ldu_detect #(.RA_W(RA_W), .NSRC(NSRC)) u_det (
    .ex_mem_read (idex_ctl.mem_read),
    .ex_rt       (idex_rt),
    .src_regs    (id_srcs),
    .stall_o     (hazard)
  );

  assign pc_we     = !hazard;
  assign ifid_we   = !hazard;
  assign ctrl_zero = hazard;

  ldu_pipe_regs #(.XLEN(XLEN), .PC_W(PC_W), .RA_W(RA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc_en       (pc_we),
    .ifid_en     (ifid_we),
    .bubble      (ctrl_zero),
    .fetch_word  (imem_instr),
    .dec_ctl     (dec_ctl),
    .dec_rt      (id_rt),
    .dec_dest    (dec_dest),
    .pc_q        (pc_out),
    .ifid_q      (ifid_instr),
    .idex_ctl_q  (idex_ctl),
    .idex_rt_q   (idex_rt),
    .idex_dest_q (idex_dest)
  );

  assign idex_mem_read  = idex_ctl.mem_read;
  assign idex_mem_write = idex_ctl.mem_write;
  assign idex_reg_write = idex_ctl.reg_write;
endmodule

// File: rtl/ldu_hazard_chk.sv
module ldu_hazard_chk #(
  parameter int XLEN = 32,
  parameter int PC_W = 16,
  parameter int RA_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] pc_out,
  input logic            ctrl_zero,
  input logic [XLEN-1:0] ifid_instr,
  input logic            idex_mem_read,
  input logic            idex_mem_write,
  input logic            idex_reg_write,
  input logic [RA_W-1:0] idex_rt
);
  localparam logic [PC_W-1:0] STEP = PC_W'(XLEN / 8);

  a_r2_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_zero |-> idex_mem_read);

  a_r7_no_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_rt == '0) |-> !ctrl_zero);

  a_r4_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_zero |=> $stable(pc_out));

  a_r4_ifid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_zero |=> $stable(ifid_instr));

  a_r5_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_zero |=> !ctrl_zero);

  a_r6_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_zero |=> (!idex_mem_read && !idex_mem_write && !idex_reg_write));

  a_r8_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_zero |=> (pc_out - $past(pc_out)) == STEP);
endmodule

bind ldu_hazard_top ldu_hazard_chk #(.XLEN(XLEN), .PC_W(PC_W), .RA_W(RA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pc_out         (pc_out),
  .ctrl_zero      (ctrl_zero),
  .ifid_instr     (ifid_instr),
  .idex_mem_read  (idex_mem_read),
  .idex_mem_write (idex_mem_write),
  .idex_reg_write (idex_reg_write),
  .idex_rt        (idex_rt)
);

// File: tb/ldu_hazard_top_test.sv
`timescale 1ns/1ps
module ldu_hazard_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_instr;
  logic [15:0] pc_out;
  logic        pc_we, ifid_we, ctrl_zero;
  logic [31:0] ifid_instr;
  logic        idex_mem_read, idex_mem_write, idex_reg_write;
  logic [4:0]  idex_rt, idex_dest;

  int checks = 0;
  int failures = 0;
  logic [31:0] prog [0:15];

  always #2 clk = ~clk;

  assign imem_instr = prog[pc_out[5:2]];

  ldu_hazard_top uut (
    .clk(clk), .rst_n(rst_n), .imem_instr(imem_instr), .pc_out(pc_out),
    .pc_we(pc_we), .ifid_we(ifid_we), .ctrl_zero(ctrl_zero),
    .ifid_instr(ifid_instr), .idex_mem_read(idex_mem_read),
    .idex_mem_write(idex_mem_write), .idex_reg_write(idex_reg_write),
    .idex_rt(idex_rt), .idex_dest(idex_dest)
  );

  function automatic logic [31:0] i_load(input int rt, input int base);
    return {6'h23, 5'(base), 5'(rt), 16'h0000};
  endfunction
  function automatic logic [31:0] i_store(input int rt, input int base);
    return {6'h2b, 5'(base), 5'(rt), 16'h0004};
  endfunction
  function automatic logic [31:0] i_add(input int rd, input int rs, input int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = 32'h0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_count(input int n, output int stalls);
    stalls = 0;
    for (int c = 0; c < n; c++) begin
      step();
      if (ctrl_zero) stalls++;
    end
  endtask

  task automatic t_reset();
    clear_prog();
    prog[0] = i_load(5, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "pc", pc_out, 0);
    chk("R1", "ifid", ifid_instr, 0);
    chk("R1", "idex ctl", {idex_mem_read, idex_mem_write, idex_reg_write}, 0);
    chk("R1", "enables", {pc_we, ifid_we, ctrl_zero}, 3'b110);
    rst_n = 1'b1;
  endtask

  task automatic t_dep_rs();
    int s;
    clear_prog();
    prog[0] = i_load(5, 1);
    prog[1] = i_add(6, 5, 2);
    do_reset();
    step();
    chk("R8", "no stall before load reaches execute", ctrl_zero, 0);
    step();
    chk("R2", "stall on rs match", {ctrl_zero, pc_we, ifid_we}, 3'b100);
    chk("R2", "pc at stall", pc_out, 8);
    step();
    chk("R4", "pc held", pc_out, 8);
    chk("R4", "ifid held", ifid_instr, prog[1]);
    chk("R5", "stall released", ctrl_zero, 0);
    chk("R6", "bubble controls", {idex_mem_read, idex_mem_write, idex_reg_write}, 0);
    step();
    chk("R4", "dependent op enters execute", {idex_reg_write, 27'(0), idex_dest}, {1'b1, 27'(0), 5'd6});
    chk("R8", "pc advances again", pc_out, 12);
    run_count(4, s);
    chk("R5", "no further stalls", s, 0);
    chk("R8", "final pc", pc_out, 28);
  endtask

  task automatic t_dep_rt();
    int s;
    clear_prog();
    prog[0] = i_load(7, 2);
    prog[1] = i_store(7, 3);
    do_reset();
    run_count(8, s);
    chk("R2", "stalls on rt match", s, 1);
    chk("R5", "pc after one stall", pc_out, 28);
  endtask

  task automatic t_independent();
    int s;
    clear_prog();
    prog[0] = i_load(5, 1);
    prog[1] = i_add(8, 2, 3);
    do_reset();
    run_count(8, s);
    chk("R8", "independent stalls", s, 0);
    chk("R8", "pc without stall", pc_out, 32);
  endtask

  task automatic t_non_load();
    int s;
    clear_prog();
    prog[0] = i_store(4, 1);
    prog[1] = i_add(8, 4, 4);
    prog[2] = i_add(9, 1, 2);
    prog[3] = i_add(3, 2, 2);
    do_reset();
    run_count(8, s);
    chk("R3", "non-load stalls", s, 0);
    chk("R3", "pc without stall", pc_out, 32);
  endtask

  task automatic t_zero_reg();
    int s;
    clear_prog();
    prog[0] = i_load(0, 1);
    prog[1] = i_add(6, 0, 0);
    do_reset();
    run_count(8, s);
    chk("R7", "load to reg 0 stalls", s, 0);
    chk("R7", "pc without stall", pc_out, 32);
  endtask

  task automatic t_chain();
    int s;
    clear_prog();
    prog[0] = i_load(5, 1);
    prog[1] = i_load(6, 5);
    prog[2] = i_add(7, 6, 0);
    do_reset();
    step();
    step();
    chk("R5", "first stall", ctrl_zero, 1);
    step();
    chk("R5", "gap after first stall", ctrl_zero, 0);
    step();
    chk("R2", "second stall from dependent load", ctrl_zero, 1);
    chk("R4", "ifid holds add", ifid_instr, prog[2]);
    run_count(6, s);
    chk("R5", "no more stalls", s, 0);
    chk("R8", "final pc after two stalls", pc_out, 32);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog req=all actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_prog();
    t_reset();
    t_dep_rs();
    t_dep_rt();
    t_independent();
    t_non_load();
    t_zero_reg();
    t_chain();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule